// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block derives the field reset of a 60 Hz, 525-line raster from a counter that advances twice per video line, one count per clock. It does not simply restart on every separated vertical sync. A pulse is only taken as the start of a new field when it lands inside an acceptance window, and the current mode picks that window. Each time a field ends, an up/down confidence counter records whether the sync was accepted or missing. A state machine uses that counter to tighten or widen the window.

There are five modes. SEARCH accepts field lengths from 488 to 576 counts. NARROW accepts 522 to 528. QUALIFY uses the narrow window but only scores pulses at exactly 525. STANDARD always resets at 525, whether or not a sync arrives. FREERUN is used when no signal is present and always resets at 528.

Transitions, by name:
- promote_narrow: SEARCH to NARROW.
- promote_qualify: NARROW to QUALIFY.
- promote_standard: QUALIFY to STANDARD.
- demote_search: NARROW or STANDARD to SEARCH.
- demote_narrow: QUALIFY to NARROW.
- lose_signal: any window mode to FREERUN.
- regain: FREERUN to SEARCH, on signal return or on an early sync.
- force_search: any mode to SEARCH, on the external request.

The outputs are the running count, a one-cycle field strobe, the mode, the length of the last field and a 60 Hz identification flag.

Top module: `vsync_divider`

## Requirements
- R1: After reset, count is 0, vreset is 0, mode is SEARCH and ratio is 576. The count then rises by one per clock. When a field ends, the next count is 0, vreset is high for exactly that one cycle, and ratio holds the length of the field just ended (the last count plus one).
- R2: Let vsync_in first be high in the cycle where count is k. If that rising edge is accepted, the count returns to 0 two clocks later, so the field length is k+2.
- R3: In SEARCH, an edge giving a length from 488 to 576 inclusive ends the field. Edges giving other lengths have no effect. If no edge is accepted, the field ends at length 576.
- R4: In SEARCH, NARROW and QUALIFY, the confidence count rises by one on an accepted pulse and falls by one on a field that ends without one. In SEARCH it never goes below 0.
- R5: In SEARCH, the 12th accepted pulse moves the block to NARROW with the confidence count cleared (promote_narrow).
- R6: In NARROW, once the count has reached 12, an accepted pulse at length 525 moves the block to QUALIFY with the count cleared (promote_qualify). At any other length the block stays in NARROW at 12.
- R7: NARROW and QUALIFY accept lengths from 522 to 528 and end a sync-less field at 528. In NARROW, a missing pulse when the count is 1 or less moves the block to SEARCH (demote_search).
- R8: In QUALIFY, the 14th accepted pulse at length 525 moves the block to STANDARD (promote_standard). An accepted pulse at another length counts as a miss. A miss when the count is 1 or less moves the block to NARROW (demote_narrow).
- R9: STANDARD always ends fields at 525. It enters with a count of 14, and each field without a pulse at 525 lowers the count. When the count would reach 10, the block moves to SEARCH (demote_search).
- R10: A field that ends without an accepted pulse while sig_present is low moves the block to FREERUN (lose_signal). FREERUN ends fields at 528 and moves to SEARCH on the first clock with sig_present high (regain).
- R11: In FREERUN, a rising edge seen while count is below 34 moves the block to SEARCH (regain). A later edge has no effect.
- R12: While force_wide is high, mode is SEARCH from the next clock, with the confidence count cleared (force_search).
- R13: id60 is high exactly when ratio is below 576 and mode is not FREERUN.
- R14: The mode codes are SEARCH 0, NARROW 1, QUALIFY 2, STANDARD 3 and FREERUN 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per half line |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Separated vertical sync, active high |
| sig_present | input | 1 | High while a transmitted signal is identified |
| force_wide | input | 1 | Request to hold the search window |
| count | output | CNT_W | Running half-line count |
| vreset | output | 1 | One-cycle strobe at the first count of a field |
| mode | output | 3 | Current mode code |
| ratio | output | CNT_W | Length of the last completed field |
| id60 | output | 1 | 60 Hz identification flag |

## Verification
Suppose vsync_in rises in the cycle where count is k. The edge register holds it at the next clock, and the field counter acts on it at the clock after that. So count 0, vreset, ratio and the new mode all appear two edges after the cycle in which the input went high, and id60 follows from ratio and mode in that same cycle. force_wide acts on mode one edge later.

The bench drives its inputs on the falling edge and samples on the next falling edge. Its reference model is advanced exactly one clock per drive. Directed checks are taken only at field boundaries, or a fixed number of steps after a stimulus, where those latencies have already elapsed.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    typedef enum logic [2:0] {
        MODE_SEARCH   = 3'd0,
        MODE_NARROW   = 3'd1,
        MODE_QUALIFY  = 3'd2,
        MODE_STANDARD = 3'd3,
        MODE_FREERUN  = 3'd4
    } vsd_mode_e;
endpackage

// File: rtl/vsd_sync_edge.sv
module vsd_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    output logic pend
);
    logic vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            pend <= 1'b0;
        end else begin
            vs_q <= vsync_in;
            pend <= vsync_in & ~vs_q;
        end
    end
endmodule

// File: rtl/vsd_field_counter.sv
module vsd_field_counter #(
    parameter int CNT_W     = 10,
    parameter int SEARCH_HI = 576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    output logic [CNT_W-1:0] count,
    output logic             vreset,
    output logic [CNT_W-1:0] ratio
);
    localparam logic [CNT_W-1:0] RATIO_INIT = CNT_W'(SEARCH_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            vreset <= 1'b0;
            ratio  <= RATIO_INIT;
        end else if (wrap) begin
            count  <= '0;
            vreset <= 1'b1;
            ratio  <= count + 1'b1;
        end else begin
            count  <= count + 1'b1;
            vreset <= 1'b0;
        end
    end
endmodule

// File: rtl/vsd_mode_fsm.sv
module vsd_mode_fsm
    import vsd_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SEARCH_LO   = 488,
    parameter int SEARCH_HI   = 576,
    parameter int NARROW_LO   = 522,
    parameter int NARROW_HI   = 528,
    parameter int STD_LEN     = 525,
    parameter int FREE_LEN    = 528,
    parameter int PROMOTE_CNT = 12,
    parameter int QUALIFY_CNT = 14,
    parameter int DEMOTE_CNT  = 10,
    parameter int BLANK_END   = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             sig_present,
    input  logic             force_wide,
    input  logic [CNT_W-1:0] count,
    output logic             wrap,
    output vsd_mode_e        mode
);
    localparam int CONF_W = $clog2(QUALIFY_CNT + 1);
    localparam logic [CNT_W-1:0]  S_LO  = CNT_W'(SEARCH_LO);
    localparam logic [CNT_W-1:0]  S_HI  = CNT_W'(SEARCH_HI);
    localparam logic [CNT_W-1:0]  N_LO  = CNT_W'(NARROW_LO);
    localparam logic [CNT_W-1:0]  N_HI  = CNT_W'(NARROW_HI);
    localparam logic [CNT_W-1:0]  STD_C = CNT_W'(STD_LEN);
    localparam logic [CNT_W-1:0]  FREE_C = CNT_W'(FREE_LEN);
    localparam logic [CNT_W-1:0]  BLK_C = CNT_W'(BLANK_END);
    localparam logic [CONF_W-1:0] PROM_M1 = CONF_W'(PROMOTE_CNT - 1);
    localparam logic [CONF_W-1:0] PROM_C  = CONF_W'(PROMOTE_CNT);
    localparam logic [CONF_W-1:0] QUAL_M1 = CONF_W'(QUALIFY_CNT - 1);
    localparam logic [CONF_W-1:0] QUAL_C  = CONF_W'(QUALIFY_CNT);
    localparam logic [CONF_W-1:0] DEM_P1  = CONF_W'(DEMOTE_CNT + 1);
    localparam logic [CONF_W-1:0] ONE_C   = CONF_W'(1);

    vsd_mode_e         state, state_n;
    logic [CONF_W-1:0] conf, conf_n;
    logic [CNT_W-1:0]  len, win_lo, win_hi, limit;
    logic              acc_en, acc, miss, early;

    assign len   = count + 1'b1;
    assign early = count < BLK_C;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MODE_SEARCH;
            conf  <= '0;
        end else begin
            state <= state_n;
            conf  <= conf_n;
        end
    end

    // outputs: window per mode and the field-end decision
    always_comb begin
        win_lo = S_LO;
        win_hi = S_HI;
        limit  = S_HI;
        acc_en = 1'b1;
        unique case (state)
            MODE_SEARCH: begin
                win_lo = S_LO;
                win_hi = S_HI;
                limit  = S_HI;
            end
            MODE_NARROW, MODE_QUALIFY: begin
                win_lo = N_LO;
                win_hi = N_HI;
                limit  = N_HI;
            end
            MODE_STANDARD: begin
                win_lo = STD_C;
                win_hi = STD_C;
                limit  = STD_C;
            end
            MODE_FREERUN: begin
                win_lo = FREE_C;
                win_hi = FREE_C;
                limit  = FREE_C;
                acc_en = 1'b0;
            end
            default: acc_en = 1'b0;
        endcase
        acc  = pend && acc_en && (len >= win_lo) && (len <= win_hi);
        miss = !acc && (len >= limit);
        wrap = acc || miss;
    end

    assign mode = state;

    // next state
    always_comb begin
        state_n = state;
        conf_n  = conf;
        unique case (state)
            MODE_SEARCH: begin
                if (acc) begin
                    if (conf == PROM_M1) begin
                        state_n = MODE_NARROW;
                        conf_n  = '0;
                    end else begin
                        conf_n = conf + 1'b1;
                    end
                end else if (miss) begin
                    if (!sig_present) begin
                        state_n = MODE_FREERUN;
                        conf_n  = '0;
                    end else if (conf != '0) begin
                        conf_n = conf - 1'b1;
                    end
                end
            end
            MODE_NARROW: begin
                if (acc) begin
                    if (conf >= PROM_M1) begin
                        if (len == STD_C) begin
                            state_n = MODE_QUALIFY;
                            conf_n  = '0;
                        end else begin
                            conf_n = PROM_C;
                        end
                    end else begin
                        conf_n = conf + 1'b1;
                    end
                end else if (miss) begin
                    if (!sig_present) begin
                        state_n = MODE_FREERUN;
                        conf_n  = '0;
                    end else if (conf <= ONE_C) begin
                        state_n = MODE_SEARCH;
                        conf_n  = '0;
                    end else begin
                        conf_n = conf - 1'b1;
                    end
                end
            end
            MODE_QUALIFY: begin
                if (acc && len == STD_C) begin
                    if (conf == QUAL_M1) begin
                        state_n = MODE_STANDARD;
                        conf_n  = QUAL_C;
                    end else begin
                        conf_n = conf + 1'b1;
                    end
                end else if (wrap) begin
                    if (!sig_present) begin
                        state_n = MODE_FREERUN;
                        conf_n  = '0;
                    end else if (conf <= ONE_C) begin
                        state_n = MODE_NARROW;
                        conf_n  = '0;
                    end else begin
                        conf_n = conf - 1'b1;
                    end
                end
            end
            MODE_STANDARD: begin
                if (acc) begin
                    if (conf < QUAL_C) conf_n = conf + 1'b1;
                end else if (miss) begin
                    if (!sig_present) begin
                        state_n = MODE_FREERUN;
                        conf_n  = '0;
                    end else if (conf <= DEM_P1) begin
                        state_n = MODE_SEARCH;
                        conf_n  = '0;
                    end else begin
                        conf_n = conf - 1'b1;
                    end
                end
            end
            MODE_FREERUN: begin
                if (sig_present || (pend && early)) begin
                    state_n = MODE_SEARCH;
                    conf_n  = '0;
                end
            end
            default: begin
                state_n = MODE_SEARCH;
                conf_n  = '0;
            end
        endcase
        if (force_wide) begin
            state_n = MODE_SEARCH;
            conf_n  = '0;
        end
    end
endmodule

// File: rtl/vsync_divider.sv
module vsync_divider
    import vsd_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SEARCH_LO   = 488,
    parameter int SEARCH_HI   = 576,
    parameter int NARROW_LO   = 522,
    parameter int NARROW_HI   = 528,
    parameter int STD_LEN     = 525,
    parameter int FREE_LEN    = 528,
    parameter int PROMOTE_CNT = 12,
    parameter int QUALIFY_CNT = 14,
    parameter int DEMOTE_CNT  = 10,
    parameter int BLANK_END   = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_in,
    input  logic             sig_present,
    input  logic             force_wide,
    output logic [CNT_W-1:0] count,
    output logic             vreset,
    output logic [2:0]       mode,
    output logic [CNT_W-1:0] ratio,
    output logic             id60
);
    localparam logic [CNT_W-1:0] ID_LIMIT = CNT_W'(SEARCH_HI);

    logic      pend;
    logic      wrap;
    vsd_mode_e mode_s;

    vsd_sync_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync_in (vsync_in),
        .pend     (pend)
    );

    vsd_mode_fsm #(
        .CNT_W       (CNT_W),
        .SEARCH_LO   (SEARCH_LO),
        .SEARCH_HI   (SEARCH_HI),
        .NARROW_LO   (NARROW_LO),
        .NARROW_HI   (NARROW_HI),
        .STD_LEN     (STD_LEN),
        .FREE_LEN    (FREE_LEN),
        .PROMOTE_CNT (PROMOTE_CNT),
        .QUALIFY_CNT (QUALIFY_CNT),
        .DEMOTE_CNT  (DEMOTE_CNT),
        .BLANK_END   (BLANK_END)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .sig_present (sig_present),
        .force_wide  (force_wide),
        .count       (count),
        .wrap        (wrap),
        .mode        (mode_s)
    );

    vsd_field_counter #(
        .CNT_W     (CNT_W),
        .SEARCH_HI (SEARCH_HI)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .count  (count),
        .vreset (vreset),
        .ratio  (ratio)
    );

    assign mode = mode_s;
    assign id60 = (ratio < ID_LIMIT) && (mode_s != MODE_FREERUN);
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker
    import vsd_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SEARCH_HI = 576,
    parameter int NARROW_LO = 522,
    parameter int NARROW_HI = 528,
    parameter int STD_LEN   = 525,
    parameter int FREE_LEN  = 528
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_wide,
    input logic [CNT_W-1:0] count,
    input logic             vreset,
    input logic [2:0]       mode,
    input logic [CNT_W-1:0] ratio,
    input logic             id60
);
    localparam logic [CNT_W-1:0] S_HI  = CNT_W'(SEARCH_HI);
    localparam logic [CNT_W-1:0] N_LO  = CNT_W'(NARROW_LO);
    localparam logic [CNT_W-1:0] N_HI  = CNT_W'(NARROW_HI);
    localparam logic [CNT_W-1:0] STD_C = CNT_W'(STD_LEN);
    localparam logic [CNT_W-1:0] FRE_C = CNT_W'(FREE_LEN);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (count == $past(count) + 1'b1)); // R1
    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |-> (count == '0)); // R1
    AST_SEARCH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        count < S_HI); // R3
    AST_NARROW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (vreset && $past(mode) == MODE_NARROW) |-> (ratio >= N_LO && ratio <= N_HI)); // R7
    AST_STANDARD_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (vreset && $past(mode) == MODE_STANDARD) |-> (ratio == STD_C)); // R9
    AST_FREERUN_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (vreset && $past(mode) == MODE_FREERUN) |-> (ratio == FRE_C)); // R10
    AST_FORCE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        force_wide |=> (mode == MODE_SEARCH)); // R12
    AST_ID_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREERUN) |-> !id60); // R13
    AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd4); // R14
endmodule

bind vsync_divider vsd_checker #(
    .CNT_W     (CNT_W),
    .SEARCH_HI (SEARCH_HI),
    .NARROW_LO (NARROW_LO),
    .NARROW_HI (NARROW_HI),
    .STD_LEN   (STD_LEN),
    .FREE_LEN  (FREE_LEN)
) u_vsd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_wide (force_wide),
    .count      (count),
    .vreset     (vreset),
    .mode       (mode),
    .ratio      (ratio),
    .id60       (id60)
);

// File: tb/tb_vsync_divider.sv
module tb_vsync_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_in = 1'b0;
    logic       sig_present = 1'b1;
    logic       force_wide = 1'b0;
    logic [9:0] count;
    logic       vreset;
    logic [2:0] mode;
    logic [9:0] ratio;
    logic       id60;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state (value after the most recent clock edge)
    int m_count = 0, m_ratio = 576, m_mode = 0, m_conf = 0;
    bit m_vreset = 0, m_pend = 0, m_vsq = 0;
    int g_tgt = 0;
    bit g_sig = 1, g_fw = 0;

    always #2 clk = ~clk;

    vsync_divider dut (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .sig_present(sig_present),
        .force_wide(force_wide), .count(count), .vreset(vreset), .mode(mode),
        .ratio(ratio), .id60(id60)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_id60(input int r, input int md);
        return (r < 576 && md != 4) ? 1 : 0;
    endfunction

    // one clock of the model, written from R2..R12
    task automatic model_advance(input bit vs, input bit sg, input bit fw);
        int len = m_count + 1;
        int lo = 488, hi = 576, lim = 576;
        bit en = 1, acc, miss, wr;
        int nm = m_mode, nc = m_conf;
        case (m_mode)
            1, 2: begin lo = 522; hi = 528; lim = 528; end
            3: begin lo = 525; hi = 525; lim = 525; end
            4: begin en = 0; lim = 528; end
            default: ;
        endcase
        acc  = m_pend && en && len >= lo && len <= hi;
        miss = !acc && len >= lim;
        wr   = acc || miss;
        case (m_mode)
            0: if (acc) begin
                   if (m_conf == 11) begin nm = 1; nc = 0; end else nc = m_conf + 1;
               end else if (miss) begin
                   if (!sg) begin nm = 4; nc = 0; end else if (m_conf > 0) nc = m_conf - 1;
               end
            1: if (acc) begin
                   if (m_conf >= 11) begin
                       if (len == 525) begin nm = 2; nc = 0; end else nc = 12;
                   end else nc = m_conf + 1;
               end else if (miss) begin
                   if (!sg) begin nm = 4; nc = 0; end
                   else if (m_conf <= 1) begin nm = 0; nc = 0; end
                   else nc = m_conf - 1;
               end
            2: if (acc && len == 525) begin
                   if (m_conf == 13) begin nm = 3; nc = 14; end else nc = m_conf + 1;
               end else if (wr) begin
                   if (!sg) begin nm = 4; nc = 0; end
                   else if (m_conf <= 1) begin nm = 1; nc = 0; end
                   else nc = m_conf - 1;
               end
            3: if (acc) begin
                   if (m_conf < 14) nc = m_conf + 1;
               end else if (miss) begin
                   if (!sg) begin nm = 4; nc = 0; end
                   else if (m_conf <= 11) begin nm = 0; nc = 0; end
                   else nc = m_conf - 1;
               end
            default: if (sg || (m_pend && m_count < 34)) begin nm = 0; nc = 0; end
        endcase
        if (fw) begin nm = 0; nc = 0; end
        m_pend = vs && !m_vsq;
        m_vsq  = vs;
        if (wr) begin m_ratio = len; m_count = 0; m_vreset = 1; end
        else begin m_count = m_count + 1; m_vreset = 0; end
        m_mode = nm;
        m_conf = nc;
    endtask

    task automatic step();
        bit vs = (g_tgt >= 2) && (m_count >= g_tgt - 2) && (m_count < g_tgt + 2);
        vsync_in    = vs;
        sig_present = g_sig;
        force_wide  = g_fw;
        model_advance(vs, g_sig, g_fw);
        @(negedge clk);
        check("R1 count", int'(count), m_count);
        check("R1 vreset", int'(vreset), int'(m_vreset));
        check("R14 mode", int'(mode), m_mode);
        check("R2 ratio", int'(ratio), m_ratio);
        check("R13 id60", int'(id60), exp_id60(m_ratio, m_mode));
    endtask

    task automatic run_steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_field(input int tgt, input bit sg, input bit fw);
        g_tgt = tgt; g_sig = sg; g_fw = fw;
        for (int i = 0; i < 800; i++) begin
            step();
            if (m_vreset) break;
        end
    endtask

    task automatic fields(input int n, input int tgt);
        for (int i = 0; i < n; i++) do_field(tgt, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed = 7;
        int r;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset vreset", int'(vreset), 0);
        check("R14 reset mode SEARCH=0", int'(mode), 0);
        check("R1 reset ratio", int'(ratio), 576);
        check("R13 reset id60", int'(id60), 0);
        rst_n = 1'b1;

        // R5: twelve accepted pulses in SEARCH
        fields(11, 525);
        check("R5 still SEARCH after 11", int'(mode), 0);
        do_field(525, 1, 0);
        check("R5 NARROW after 12th", int'(mode), 1);
        check("R2 ratio equals sync position plus two", int'(ratio), 525);
        check("R13 id60 at 525", int'(id60), 1);

        // R6: non-525 keeps NARROW
        fields(12, 524);
        check("R6 stays NARROW at 524", int'(mode), 1);
        check("R4 ratio 524", int'(ratio), 524);
        do_field(530, 1, 0);
        check("R7 narrow miss wraps at 528", int'(ratio), 528);
        check("R4 NARROW after one miss", int'(mode), 1);
        do_field(525, 1, 0);
        check("R6 QUALIFY on 525 at count 12", int'(mode), 2);

        // R8: fourteen 525 pulses
        fields(13, 525);
        check("R8 QUALIFY after 13", int'(mode), 2);
        do_field(525, 1, 0);
        check("R8 STANDARD after 14th", int'(mode), 3);

        // R9: misses in STANDARD
        fields(3, 0);
        check("R9 STANDARD after 3 misses", int'(mode), 3);
        check("R9 ratio stays 525", int'(ratio), 525);
        do_field(0, 1, 0);
        check("R9 SEARCH after 4th miss", int'(mode), 0);

        // R3: search window edges
        do_field(480, 1, 0);
        check("R3 early edge ignored, wrap at 576", int'(ratio), 576);
        check("R13 id60 low at 576", int'(id60), 0);
        do_field(488, 1, 0);
        check("R3 lower edge 488 accepted", int'(ratio), 488);
        do_field(576, 1, 0);
        check("R3 upper edge 576 accepted", int'(ratio), 576);

        // R10 / R11: no signal
        do_field(0, 0, 0);
        check("R10 FREERUN on miss without signal", int'(mode), 4);
        do_field(0, 0, 0);
        check("R10 FREERUN wraps at 528", int'(ratio), 528);
        check("R13 id60 low in FREERUN", int'(id60), 0);
        g_tgt = 12; g_sig = 0; g_fw = 0;
        run_steps(13);
        check("R11 early sync in FREERUN gives SEARCH", int'(mode), 0);
        do_field(0, 0, 0);
        do_field(100, 0, 0);
        check("R11 late sync ignored in FREERUN", int'(mode), 4);
        check("R11 late sync ratio 528", int'(ratio), 528);
        do_field(0, 1, 0);
        check("R10 signal return gives SEARCH", int'(mode), 0);
        check("R10 search wrap 576", int'(ratio), 576);

        // R12 / R7 / R8 demotions
        do_field(525, 1, 1);
        check("R12 force_wide SEARCH", int'(mode), 0);
        fields(12, 525);
        check("R5 NARROW again", int'(mode), 1);
        do_field(0, 1, 0);
        check("R7 NARROW miss at count 0 gives SEARCH", int'(mode), 0);
        check("R7 narrow miss ratio 528", int'(ratio), 528);
        fields(24, 525);
        check("R6 QUALIFY reached", int'(mode), 2);
        do_field(524, 1, 0);
        check("R8 non-525 at count 0 gives NARROW", int'(mode), 1);
        g_tgt = 525; g_sig = 1; g_fw = 1;
        run_steps(3);
        check("R12 force_wide mid-field", int'(mode), 0);
        g_fw = 0;

        // constrained random fields
        for (int f = 0; f < 100; f++) begin
            int p = $urandom_range(99, 0);
            int tgt;
            bit sg = ($urandom_range(99, 0) >= 5);
            bit fw = ($urandom_range(99, 0) < 2);
            if (p < 60) tgt = 525;
            else if (p < 75) tgt = $urandom_range(530, 520);
            else if (p < 90) tgt = $urandom_range(600, 480);
            else tgt = 0;
            do_field(tgt, sg, fw);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule